// File: doc/BRIEF.md
# Wait-Stretched Asynchronous Memory Cycle Sequencer

This block runs one asynchronous read or write on an external memory bus for each host request. The cycle is timed in functional-clock cycles by a single phase counter. Three programmable marks sit on that counter: when chip-select drops, when read data is sampled, and when the whole cycle ends. The external WAIT line passes through a two-flop synchronizer and a polarity select. When monitoring is enabled for the current direction, an active WAIT freezes the phase counter. Every later mark then moves out by the same number of cycles, so the cycle can run past its programmed length.

A 9-bit countdown watchdog guards the access. It loads a programmable start value when the access begins and reloads each time the memory signals a data beat. If it sits at zero in a cycle with no beat while enabled, the access is abandoned. The strobes drop, the host sees an error response, and a sticky error flag is raised until it is cleared.

Top module: `amem_wait_seq`

## Requirements
- R1: After reset, chip-select, output-enable and write-enable are low, req_ready is high, rsp_valid is low and err_sticky is low.
- R2: A read accepted on edge E is active for cfg_cycle+1 cycles when not frozen. mem_cs and mem_oe are high while the phase count is below cfg_cs_off. mem_rdata is captured at phase cfg_access and returned on rsp_rdata with a one-cycle rsp_valid after the last active cycle.
- R3: A write drives mem_we in place of mem_oe, holds the accepted req_wdata on mem_wdata, and never raises mem_oe and mem_we together.
- R4: With read monitoring on, each cycle in which the synchronized WAIT is active holds the phase count. Chip-select drop, data capture and cycle end all move later by that many cycles.
- R5: With read monitoring off, WAIT has no effect on a read's timing.
- R6: Read and write monitoring have separate enables. A write ignores WAIT unless cfg_wr_wait_en is set, whatever cfg_rd_wait_en is.
- R7: cfg_wait_pol=1 makes a high WAIT active. cfg_wait_pol=0 makes a low WAIT active. WAIT is sampled through two flops before use.
- R8: With cfg_to_en set, an active cycle with no mem_dvalid and a watchdog count of zero aborts the access. The strobes drop on the next cycle, and rsp_valid with rsp_err=1 is reported.
- R9: Every mem_dvalid beat reloads the watchdog with cfg_to_start. Between beats the watchdog counts down by one per cycle, so beats spaced no more than cfg_to_start+1 cycles apart prevent an abort.
- R10: With cfg_to_en clear, no abort occurs however long WAIT stays active.
- R11: An abort sets err_sticky, which stays high until err_clr is asserted. Setting takes priority over clearing.
- R12: A start value of zero with the watchdog enabled aborts in the first active cycle that has no mem_dvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cs_off | input | TW | Phase at which chip-select and strobes drop |
| cfg_access | input | TW | Phase at which read data is captured |
| cfg_cycle | input | TW | Last phase of the cycle (must be >= cfg_access) |
| cfg_rd_wait_en | input | 1 | Enable WAIT freeze for reads |
| cfg_wr_wait_en | input | 1 | Enable WAIT freeze for writes |
| cfg_wait_pol | input | 1 | WAIT active level (1 high, 0 low) |
| cfg_to_en | input | 1 | Watchdog enable |
| cfg_to_start | input | TOW | Watchdog start value |
| req_valid | input | 1 | Host request strobe, taken when req_ready is high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Engine idle and able to take a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a watchdog abort (valid with rsp_valid) |
| rsp_rdata | output | DW | Captured read data |
| err_sticky | output | 1 | Latched abort flag |
| err_clr | input | 1 | Clears err_sticky |
| mem_cs | output | 1 | Chip-select, active high |
| mem_oe | output | 1 | Output-enable, active high |
| mem_we | output | 1 | Write-enable, active high |
| mem_wdata | output | DW | Write data to memory |
| mem_rdata | input | DW | Read data from memory |
| mem_dvalid | input | 1 | Memory data beat indication |
| mem_wait | input | 1 | Asynchronous WAIT line |

## Verification
Reads and writes are first run with WAIT idle, which fixes the base mark positions. A WAIT pulse is then placed in the middle of the access. Applied with monitoring on and off, and to each direction with only the other direction's enable set, it shows whether the freeze is tied to the right enable. Repeating the pulse with inverted polarity separates active-high from active-low decoding. On the watchdog side, a run with no beats tells abort from completion. Periodic beats at the reload limit show that the count reloads. A long WAIT with the watchdog disabled, and a zero start value with beats held high and then absent, cover the edge cases.

// File: rtl/amem_wait_seq.sv
module amem_wait_seq #(
  parameter int DW  = 16,
  parameter int TW  = 6,
  parameter int TOW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  cfg_cs_off,
  input  logic [TW-1:0]  cfg_access,
  input  logic [TW-1:0]  cfg_cycle,
  input  logic           cfg_rd_wait_en,
  input  logic           cfg_wr_wait_en,
  input  logic           cfg_wait_pol,
  input  logic           cfg_to_en,
  input  logic [TOW-1:0] cfg_to_start,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [DW-1:0]  req_wdata,
  output logic           req_ready,
  output logic           rsp_valid,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_rdata,
  output logic           err_sticky,
  input  logic           err_clr,
  output logic           mem_cs,
  output logic           mem_oe,
  output logic           mem_we,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_dvalid,
  input  logic           mem_wait
);
  logic           busy, wr;
  logic [1:0]     wait_q;
  logic [TW-1:0]  tcnt;
  logic [TOW-1:0] to_cnt;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic           wait_act, hold, expire;

  assign wait_act = (wait_q[1] == cfg_wait_pol);
  assign hold     = busy && wait_act && (wr ? cfg_wr_wait_en : cfg_rd_wait_en);
  assign expire   = busy && cfg_to_en && !mem_dvalid && (to_cnt == '0);

  assign req_ready = !busy;
  assign mem_cs    = busy && (tcnt < cfg_cs_off);
  assign mem_oe    = mem_cs && !wr;
  assign mem_we    = mem_cs && wr;
  assign mem_wdata = wdata_q;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q     <= '0;
      busy       <= 1'b0;
      wr         <= 1'b0;
      tcnt       <= '0;
      to_cnt     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      wait_q    <= {wait_q[0], mem_wait};
      rsp_valid <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy    <= 1'b1;
          wr      <= req_write;
          wdata_q <= req_wdata;
          tcnt    <= '0;
          to_cnt  <= cfg_to_start;
        end
      end else begin
        if (mem_dvalid)         to_cnt <= cfg_to_start;
        else if (to_cnt != '0)  to_cnt <= to_cnt - 1'b1;
        if (expire) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
        end else if (!hold) begin
          if (!wr && tcnt == cfg_access) rdata_q <= mem_rdata;
          if (tcnt == cfg_cycle) begin
            busy      <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
      end
      if (expire)       err_sticky <= 1'b1;
      else if (err_clr) err_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/amem_wait_seq_chk.sv
module amem_wait_seq_chk #(
  parameter int TW  = 6,
  parameter int TOW = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           hold,
  input logic [TW-1:0]  tcnt,
  input logic [TOW-1:0] to_cnt,
  input logic [TOW-1:0] cfg_to_start,
  input logic           cfg_to_en,
  input logic           mem_dvalid,
  input logic           mem_cs,
  input logic           mem_oe,
  input logic           mem_we,
  input logic           rsp_valid,
  input logic           rsp_err,
  input logic           err_sticky
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_cs);
  assert_strobe_in_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe || mem_we) |-> mem_cs);
  assert_oe_we_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_oe && mem_we));
  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hold) |=> (!busy || $stable(tcnt)));
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_to_en && !mem_dvalid && to_cnt == '0) |=> (!busy && rsp_valid && rsp_err));
  assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_dvalid) |=> (to_cnt == $past(cfg_to_start)));
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> err_sticky);
endmodule

bind amem_wait_seq amem_wait_seq_chk #(.TW(TW), .TOW(TOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .hold(hold), .tcnt(tcnt),
  .to_cnt(to_cnt), .cfg_to_start(cfg_to_start), .cfg_to_en(cfg_to_en),
  .mem_dvalid(mem_dvalid), .mem_cs(mem_cs), .mem_oe(mem_oe), .mem_we(mem_we),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .err_sticky(err_sticky)
);

// File: tb/amem_wait_seq_tb.sv
`timescale 1ns/1ps
module amem_wait_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] cfg_cs_off = 6'd4, cfg_access = 6'd3, cfg_cycle = 6'd6;
  logic cfg_rd_wait_en = 0, cfg_wr_wait_en = 0, cfg_wait_pol = 1, cfg_to_en = 0;
  logic [8:0] cfg_to_start = 9'd0;
  logic req_valid = 0, req_write = 0, err_clr = 0, mem_dvalid = 0, mem_wait = 0;
  logic [15:0] req_wdata = '0, mem_rdata = 16'hA5C3;
  logic req_ready, rsp_valid, rsp_err, err_sticky, mem_cs, mem_oe, mem_we;
  logic [15:0] rsp_rdata, mem_wdata;

  always #2.5 clk = ~clk;

  amem_wait_seq u_dut (.*);

  int checks = 0, failures = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_busy, m_wr, m_t, m_to, m_rsp, m_rerr, m_sticky, ws1, ws2;
  logic [15:0] m_rdata, m_wdata;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_t = 0; m_to = 0; m_rsp = 0; m_rerr = 0;
      m_sticky = 0; ws1 = 0; ws2 = 0; m_rdata = '0; m_wdata = '0;
    end else begin
      int frozen, timed_out;
      frozen = m_busy && (ws2 == int'(cfg_wait_pol)) &&
               (m_wr ? cfg_wr_wait_en : cfg_rd_wait_en);
      timed_out = m_busy && cfg_to_en && !mem_dvalid && m_to == 0;
      m_rsp = 0;
      if (!m_busy) begin
        if (req_valid) begin
          m_busy = 1; m_wr = req_write; m_wdata = req_wdata; m_t = 0;
          m_to = cfg_to_start;
        end
      end else begin
        if (timed_out) begin
          m_busy = 0; m_rsp = 1; m_rerr = 1;
        end else if (!frozen) begin
          if (!m_wr && m_t == cfg_access) m_rdata = mem_rdata;
          if (m_t == cfg_cycle) begin m_busy = 0; m_rsp = 1; m_rerr = 0; end
          else m_t++;
        end
        if (!timed_out || 1) begin
          if (mem_dvalid) m_to = cfg_to_start;
          else if (m_to > 0) m_to--;
        end
      end
      if (timed_out) m_sticky = 1;
      else if (err_clr) m_sticky = 0;
      ws2 = ws1; ws1 = mem_wait;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic e_cs, e_oe, e_we, bad;
      e_cs = m_busy && (m_t < cfg_cs_off);
      e_oe = e_cs && !m_wr;
      e_we = e_cs && m_wr;
      bad = (mem_cs !== e_cs) || (mem_oe !== e_oe) || (mem_we !== e_we) ||
            (req_ready !== !m_busy) || (rsp_valid !== m_rsp[0]) ||
            (err_sticky !== m_sticky[0]) ||
            (m_rsp && rsp_err !== m_rerr[0]) ||
            (m_rsp && !m_rerr && !m_wr && rsp_rdata !== m_rdata) ||
            (e_we && mem_wdata !== m_wdata);
      checks++;
      if (bad) begin
        failures++;
        $display("FAIL %s t=%0t cs/oe/we=%b%b%b exp %b%b%b ready=%b exp %b rsp=%b/%b exp %0d/%0d sticky=%b exp %0d rdata=%h exp %h wdata=%h exp %h",
                 cur_req, $time, mem_cs, mem_oe, mem_we, e_cs, e_oe, e_we,
                 req_ready, !m_busy, rsp_valid, rsp_err, m_rsp, m_rerr,
                 err_sticky, m_sticky, rsp_rdata, m_rdata, mem_wdata, m_wdata);
      end
    end
  end

  task automatic run(input bit w, input logic [15:0] d, input int ws,
                     input int wl, input int dvp);
    @(negedge clk);
    req_valid = 1; req_write = w; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 400; k++) begin
      mem_wait   = (k >= ws && k < ws + wl) ? cfg_wait_pol : !cfg_wait_pol;
      mem_dvalid = (dvp > 0) && (k % dvp == dvp - 1);
      @(negedge clk);
      if (req_ready) break;
    end
    mem_wait = !cfg_wait_pol; mem_dvalid = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (mem_cs || mem_oe || mem_we || !req_ready || rsp_valid || err_sticky) begin
      failures++;
      $display("FAIL R1 reset outputs cs=%b oe=%b we=%b ready=%b rsp=%b sticky=%b exp 0 0 0 1 0 0",
               mem_cs, mem_oe, mem_we, req_ready, rsp_valid, err_sticky);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    cur_req = "R2"; run(0, 0, 0, 0, 0);
    cur_req = "R3"; run(1, 16'h3C5A, 0, 0, 0);
    cfg_rd_wait_en = 1;
    cur_req = "R4"; mem_rdata = 16'h1234; run(0, 0, 1, 4, 0);
    cfg_rd_wait_en = 0;
    cur_req = "R5"; mem_rdata = 16'h4321; run(0, 0, 1, 4, 0);
    cfg_rd_wait_en = 1;
    cur_req = "R6"; run(1, 16'h0F0F, 1, 4, 0);
    cfg_wr_wait_en = 1; run(1, 16'hF0F0, 2, 5, 0);
    cfg_wait_pol = 0; mem_wait = 1; repeat (4) @(negedge clk);
    cur_req = "R7"; mem_rdata = 16'h7777; run(0, 0, 1, 3, 0);
    cfg_wait_pol = 1; mem_wait = 0; repeat (4) @(negedge clk);
    cfg_cycle = 6'd20; cfg_to_en = 1; cfg_to_start = 9'd5;
    cur_req = "R8"; run(0, 0, 0, 0, 0);
    cur_req = "R11"; repeat (5) @(negedge clk);
    err_clr = 1; @(negedge clk); err_clr = 0; repeat (2) @(negedge clk);
    cfg_to_start = 9'd3;
    cur_req = "R9"; mem_rdata = 16'h9999; run(0, 0, 0, 0, 4);
    cfg_to_en = 0; cfg_cycle = 6'd6;
    cur_req = "R10"; run(0, 0, 1, 30, 0);
    cfg_to_en = 1; cfg_to_start = 9'd0;
    cur_req = "R12"; run(1, 16'hBEEF, 0, 0, 1);
    run(0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule